// File: doc/BRIEF.md
# Two-Level Sequencing Strobe Generator

This block produces the timing strobes for the control sequence of a memory-management unit. Its state has two parts. A major field is a small binary counter. A minor field is a twisted-ring (Johnson) counter. Each part is decoded to a one-hot vector. Every major/minor combination also gets its own strobe, in an active-high form and an active-low form. Logic downstream can then act on one pair wire and needs no decoder of its own.

The sequencer waits in state 0.0 until a start request arrives. It then steps the minor field on every clock where the advance enable is high. Each time the minor field completes its ring, the major field counts up by one. When the major field wraps back to zero, the sequencer drops busy and returns to idle. The minor decoder looks at only two adjacent bits for each strobe. Any code outside the legal ring is forced to all zeros on the next clock, so the minor field can never lock up in a stray pattern.

Top module: `mmt_seq_gen`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are as follows: busy is 0, major_oh is 0001, minor_oh has only bit 0 set, every pair_hi bit is 0 and every pair_lo_n bit is 1.
- R2: major_oh has exactly one bit set. Bit m is set when the major value is m, for m from 0 to 3.
- R3: The minor field runs through the codes 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 and then back to 0000. minor_oh bit k marks the k-th code in that list, and exactly one bit of minor_oh is set at all times.
- R4: A start_req seen at a clock edge while idle sets busy at that edge, with the state at 0.0. A start_req while busy has no effect.
- R5: While busy, each clock edge with adv_en high moves the minor field one place along the ring. With adv_en low, the state holds.
- R6: The major value goes up by one exactly when the minor field wraps from 1000 to 0000. At every other edge it holds.
- R7: The sequence ends at the minor wrap taken in major state 3. At that edge the state returns to 0.0 and busy clears, so a full run takes 32 advancing edges.
- R8: While busy, exactly one pair_hi bit is set, at index major*8 + minor_index. While idle, pair_hi is all zeros.
- R9: pair_lo_n is always the bitwise inverse of pair_hi.
- R10: While idle, adv_en has no effect. The state stays at 0.0 and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Starts a sequence when idle |
| adv_en | input | 1 | Advance enable, one step per clock while busy |
| major_oh | output | 2**MAJ_W | One-hot major state |
| minor_oh | output | 2*MIN_W | One-hot minor state, in ring order |
| pair_hi | output | 2**MAJ_W*2*MIN_W | Active-high strobe for each major/minor pair |
| pair_lo_n | output | 2**MAJ_W*2*MIN_W | Active-low strobe for each major/minor pair |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench builds the block with MAJ_W=2 and MIN_W=4. That gives four major states, an eight-step ring and 32 pair strobes, so a full run can be walked edge by edge and every pair index visited. With these widths both wrap points are reachable in a short run: the minor wrap from 1000 to 0000 and the final major wrap that ends a sequence. The bench also reaches the collision where an end and a fresh start request fall on the same edge, and gapped advance patterns that hold the state partway through.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

   // Code of the k-th position of a twisted ring of width n (k < 2n).
   function automatic logic [31:0] ring_code(input int k, input int n);
      logic [31:0] ones_n;
      ones_n = (32'd1 << n) - 32'd1;
      if (k <= n)
         return (32'd1 << k) - 32'd1;
      else
         return ones_n & ~((32'd1 << (k - n)) - 32'd1);
   endfunction

endpackage

// File: rtl/mmt_major_ctr.sv
module mmt_major_ctr #(
   parameter int W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                inc,
   output logic [(1<<W)-1:0]   oh,
   output logic                at_last
);
   localparam int N = 1 << W;

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (inc)
         cnt_q <= cnt_q + W'(1);
   end

   for (genvar m = 0; m < N; m++) begin : g_dec
      assign oh[m] = (cnt_q == W'(m));
   end

   assign at_last = (cnt_q == W'(N - 1));

   AST_MAJ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oh) == 1) else $error("major strobe not one-hot"); // R2
   AST_MAJ_INC: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> cnt_q == W'($past(cnt_q) + W'(1))) else $error("major did not count"); // R6
   AST_MAJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt_q)) else $error("major moved without wrap"); // R6

endmodule

// File: rtl/mmt_ring_ctr.sv
module mmt_ring_ctr
   import mmt_pkg::*;
#(
   parameter int W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [2*W-1:0]   oh,
   output logic             wrap
);
   localparam int S = 2 * W;

   logic [W-1:0] q_q, q_nxt;
   logic [S-1:0] legal_hit;
   logic         legal;

   for (genvar k = 0; k < S; k++) begin : g_legal
      assign legal_hit[k] = (q_q == W'(ring_code(k, W)));
   end
   assign legal = |legal_hit;

   // Two-bit adjacent decode of each ring position
   assign oh[0] = ~q_q[W-1] & ~q_q[0];
   for (genvar k = 1; k < W; k++) begin : g_fill
      assign oh[k] = q_q[k-1] & ~q_q[k];
   end
   assign oh[W] = q_q[W-1] & q_q[0];
   for (genvar k = W + 1; k < S; k++) begin : g_drain
      assign oh[k] = ~q_q[k-W-1] & q_q[k-W];
   end

   always_comb begin
      if (!legal)
         q_nxt = '0;
      else if (step)
         q_nxt = {q_q[W-2:0], ~q_q[W-1]};
      else
         q_nxt = q_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_q <= '0;
      else
         q_q <= q_nxt;
   end

   assign wrap = step & oh[S-1];

   AST_MIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oh) == 1) else $error("minor strobe not one-hot"); // R3
   AST_MIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> oh == {$past(oh[S-2:0]), $past(oh[S-1])}) else $error("minor step wrong"); // R5
   AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(q_q)) else $error("minor moved without step"); // R5

endmodule

// File: rtl/mmt_pair_dec.sv
module mmt_pair_dec #(
   parameter int NMAJ = 4,
   parameter int NMIN = 8
) (
   input  logic                  en,
   input  logic [NMAJ-1:0]       maj_oh,
   input  logic [NMIN-1:0]       min_oh,
   output logic [NMAJ*NMIN-1:0]  hi,
   output logic [NMAJ*NMIN-1:0]  lo_n
);
   for (genvar m = 0; m < NMAJ; m++) begin : g_maj
      for (genvar n = 0; n < NMIN; n++) begin : g_min
         assign lo_n[m*NMIN + n] = ~(en & maj_oh[m] & min_oh[n]);
      end
   end
   assign hi = ~lo_n;
endmodule

// File: rtl/mmt_seq_gen.sv
module mmt_seq_gen #(
   parameter int MAJ_W = 2,
   parameter int MIN_W = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 start_req,
   input  logic                                 adv_en,
   output logic [(1<<MAJ_W)-1:0]                major_oh,
   output logic [2*MIN_W-1:0]                   minor_oh,
   output logic [(1<<MAJ_W)*2*MIN_W-1:0]        pair_hi,
   output logic [(1<<MAJ_W)*2*MIN_W-1:0]        pair_lo_n,
   output logic                                 busy
);
   localparam int NMAJ  = 1 << MAJ_W;
   localparam int NMIN  = 2 * MIN_W;
   localparam int NPAIR = NMAJ * NMIN;

   if (MAJ_W < 1 || MAJ_W > 4) begin : g_bad_maj
      $error("MAJ_W must be 1..4");
   end
   if (MIN_W < 2 || MIN_W > 8) begin : g_bad_min
      $error("MIN_W must be 2..8");
   end

   logic busy_q, step, min_wrap, maj_last, seq_end;

   assign step    = busy_q & adv_en;
   assign seq_end = min_wrap & maj_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_q <= 1'b0;
      else if (busy_q)
         busy_q <= ~seq_end;
      else
         busy_q <= start_req;
   end

   mmt_ring_ctr #(.W(MIN_W)) u_minor (
      .clk(clk), .rst_n(rst_n), .step(step), .oh(minor_oh), .wrap(min_wrap)
   );

   mmt_major_ctr #(.W(MAJ_W)) u_major (
      .clk(clk), .rst_n(rst_n), .inc(min_wrap), .oh(major_oh), .at_last(maj_last)
   );

   mmt_pair_dec #(.NMAJ(NMAJ), .NMIN(NMIN)) u_pairs (
      .en(busy_q), .maj_oh(major_oh), .min_oh(minor_oh), .hi(pair_hi), .lo_n(pair_lo_n)
   );

   assign busy = busy_q;

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_req) |=> (busy && major_oh[0] && minor_oh[0])) else $error("start failed"); // R4
   AST_SEQ_END: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && adv_en && major_oh[NMAJ-1] && minor_oh[NMIN-1]) |=> (!busy && major_oh[0] && minor_oh[0]))
      else $error("sequence end wrong"); // R7
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_req) |=> (!busy && $stable(major_oh) && $stable(minor_oh))) else $error("idle moved"); // R10
   AST_PAIR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $countones(pair_hi) == 1) else $error("pair strobe count"); // R8
   AST_PAIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> pair_hi == '0) else $error("pair strobe while idle"); // R8
   AST_PAIR_POL: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_hi & pair_lo_n) == '0 && (pair_hi | pair_lo_n) == {NPAIR{1'b1}}) else $error("polarity"); // R9

endmodule

// File: tb/mmt_seq_gen_test.sv
module mmt_seq_gen_test;
   localparam int MAJ_W = 2;
   localparam int MIN_W = 4;
   localparam int NMIN  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0;
   logic adv_en = 1'b0;
   logic [3:0]  major_oh;
   logic [7:0]  minor_oh;
   logic [31:0] pair_hi, pair_lo_n;
   logic        busy;

   int total = 0;
   int bad = 0;
   int m_maj = 0;
   int m_min = 0;
   bit m_busy = 1'b0;

   always #10 clk = ~clk;

   mmt_seq_gen #(.MAJ_W(MAJ_W), .MIN_W(MIN_W)) uut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .adv_en(adv_en),
      .major_oh(major_oh), .minor_oh(minor_oh), .pair_hi(pair_hi),
      .pair_lo_n(pair_lo_n), .busy(busy)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h (model %0d.%0d busy=%0d)",
                  req, what, act, exp, m_maj, m_min, m_busy);
      end
   endtask

   task automatic chk_all(string req);
      logic [31:0] e_pair;
      e_pair = m_busy ? (32'd1 << (m_maj * NMIN + m_min)) : 32'd0;
      chk({req, " R2"}, "major_oh", {28'd0, major_oh}, 32'd1 << m_maj);
      chk({req, " R3"}, "minor_oh", {24'd0, minor_oh}, 32'd1 << m_min);
      chk({req, " R8"}, "pair_hi", pair_hi, e_pair);
      chk({req, " R9"}, "pair_lo_n", pair_lo_n, ~e_pair);
      chk(req, "busy", {31'd0, busy}, {31'd0, m_busy});
   endtask

   task automatic cycle(bit s, bit a, string req);
      start_req = s;
      adv_en = a;
      if (!m_busy) begin
         if (s) m_busy = 1'b1;
      end else if (a) begin
         if (m_min == NMIN - 1) begin
            m_min = 0;
            if (m_maj == 3) begin
               m_maj = 0;
               m_busy = 1'b0;
            end else m_maj++;
         end else m_min++;
      end
      @(posedge clk);
      @(negedge clk);
      chk_all(req);
   endtask

   task automatic drain();
      while (m_busy) cycle(1'b0, 1'b1, "R7");
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_all("R1 in reset");
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk_all("R1 after release");
   endtask

   task automatic t_idle_adv();
      for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, "R10");
   endtask

   task automatic t_full_run();
      cycle(1'b1, 1'b0, "R4");
      for (int i = 0; i < 31; i++) cycle(1'b0, 1'b1, "R5 R6");
      chk("R7", "busy before last step", {31'd0, busy}, 32'd1);
      cycle(1'b0, 1'b1, "R7");
      chk("R7", "busy after 32 steps", {31'd0, busy}, 32'd0);
   endtask

   task automatic t_gapped();
      cycle(1'b1, 1'b1, "R4");
      for (int i = 0; i < 40; i++)
         cycle(i == 10, (i % 3) != 0, (i == 10) ? "R4 start while busy" : "R5 gapped");
      drain();
   endtask

   task automatic t_hold();
      cycle(1'b1, 1'b0, "R4");
      for (int i = 0; i < 9; i++) cycle(1'b0, 1'b1, "R6");
      for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, "R5 hold");
      drain();
   endtask

   task automatic t_end_with_start();
      cycle(1'b1, 1'b0, "R4");
      for (int i = 0; i < 31; i++) cycle(1'b0, 1'b1, "R5");
      cycle(1'b1, 1'b1, "R7 end with start");
      cycle(1'b1, 1'b0, "R4 restart");
      drain();
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_idle_adv();
      t_full_run();
      t_gapped();
      t_hold();
      t_end_with_start();
      t_idle_adv();
      summary();
      $finish;
   end
endmodule